// File: doc/BRIEF.md
# I2C Register Port with Auto-Increment Pointer

This block is an I2C slave that fills a small bank of byte-wide control registers. SCL and SDA are brought into the system clock domain through synchronizer flops. All bus timing is then recovered by oversampling: clock edges, START, repeated START and STOP are detected from the sampled levels. The slave answers to one 7-bit address. The upper six bits of that address are fixed by a parameter, and the lowest bit follows a strap pin.

The first byte after a write address sets a pointer. The low bits of that pointer byte select a register, and bit 7 chooses whether the pointer steps forward after every data byte. Data bytes that follow are written to the selected register. A read address instead streams register contents out from the pointer, most significant bit first. The whole register bank is visible as a flat output vector for the logic it controls.

The same strap pin also acts as a select line. Its first falling edge after reset sets a sticky flag that hands the pins to a separate SPI engine. From then on, the I2C engine stays silent. There is no streaming interface at the block edge: every pin is a plain level, and the register vector is continuously valid.

Top module: `i2c_regport`

## Requirements
- R1: The port acknowledges (pulls SDA low during the ninth SCL period) an address byte whose bits 7..2 equal binary 001100 and whose bit 1 equals the synchronized strap level. Bit 0 of that byte is the direction: 0 means write, 1 means read.
- R2: An address byte that does not match is not acknowledged. Every byte after it is also not acknowledged and changes nothing, until the next START.
- R3: The first byte after a write address is the pointer byte. Bit 7 is the step-enable flag, and bits 4..0 give the register index; bits 6..5 are ignored. The pointer byte itself is acknowledged and writes no register.
- R4: With the step flag at 1, each data byte goes to the current index and the index then advances by one. Index 31 advances to 0.
- R5: With the step flag at 0, every data byte goes to the same register, and no other register changes.
- R6: After a read address, the port drives the byte at the current index, MSB first. Each bit changes only while SCL is low. The index advances after each byte only when the step flag is 1.
- R7: A master NACK on a read byte ends the read. SDA is released and nothing more is driven until the next START.
- R8: A STOP returns the port to idle. A START or repeated START always restarts address matching, so the byte after a new write address is again a pointer byte.
- R9: After reset, all 32 registers read zero, SDA is released and the SPI flag is 0.
- R10: A high-to-low transition of the synchronized strap after reset sets the SPI flag. The flag stays set until reset. While it is set, the port never drives SDA and no register changes.
- R11: The port only starts pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must be much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (wired-AND bus) |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 1 | Address strap, also the SPI select |
| spi_mode_o | output | 1 | Sticky flag: the port has been handed to SPI |
| regs_o | output | 256 | Register bank, register i in bits 8*i+7 down to 8*i |

## Verification
A wrong pointer or wrong step handling shows up on regs_o within a few system clocks of the SCL fall that ends a data byte. Either the wrong byte lane changes, or two lanes change at once. The same fault also appears during a later read, as a wrong bit on SDA in the very first data bit. A mistake in the state machine or in address matching shows at the ninth SCL high of the affected byte, as a missing or unexpected ACK. A broken SPI flag shows within three clocks of the strap fall, and a later transfer then either writes a register or drives SDA.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } port_state_e;

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int          STAGES  = 2,
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[s] <= RST_VAL;
      end else if (s == 0) begin
        chain[s] <= d_i;
      end else begin
        chain[s] <= chain[(s > 0) ? s - 1 : 0];
      end
    end
  end

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_regport_cond.sv
module i2c_regport_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic strap_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c,
  output logic strap_fall
);

  logic scl_d, sda_d, strap_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d   <= 1'b1;
      sda_d   <= 1'b1;
      strap_d <= 1'b0;
    end else begin
      scl_d   <= scl_s;
      sda_d   <= sda_s;
      strap_d <= strap_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_d;
  assign scl_fall   = ~scl_s & scl_d;
  // SDA moving while SCL is steadily high marks a bus condition
  assign start_c    = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c     = scl_s & scl_d & ~sda_d & sda_s;
  // strap_d resets low, so a strap held low from power-up never counts
  assign strap_fall = strap_d & ~strap_s;

endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
  parameter int NREGS = 32,
  parameter int IDXW  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [IDXW-1:0]       widx_i,
  input  logic [7:0]            wdata_i,
  input  logic [IDXW-1:0]       ridx_i,
  output logic [7:0]            rdata_o,
  output logic [NREGS*8-1:0]    regs_o
);

  logic [7:0] mem [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (we_i && (int'(widx_i) == i)) begin
        mem[i] <= wdata_i;
      end
    end
    assign regs_o[i*8 +: 8] = mem[i];
  end

  always_comb begin
    rdata_o = '0;
    if (int'(ridx_i) < NREGS) rdata_o = mem[ridx_i];
  end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
  import i2c_regport_pkg::*;
#(
  parameter int         NREGS       = 32,
  parameter logic [5:0] ADDR_HI     = 6'b001100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic               strap_i,
  output logic               spi_mode_o,
  output logic [NREGS*8-1:0] regs_o
);

  localparam int IDXW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [2:0] raw_v, syn_v;
  logic scl_s, sda_s, strap_s;
  logic scl_rise, scl_fall, start_c, stop_c, strap_fall;

  assign raw_v = {strap_i, sda_i, scl_i};

  i2c_regport_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (3),
    .RST_VAL(3'b011)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_v),
    .q_o  (syn_v)
  );

  assign scl_s   = syn_v[0];
  assign sda_s   = syn_v[1];
  assign strap_s = syn_v[2];

  i2c_regport_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .strap_s   (strap_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_c   (start_c),
    .stop_c    (stop_c),
    .strap_fall(strap_fall)
  );

  port_state_e       state;
  logic [7:0]        shreg;
  logic [2:0]        bitcnt;
  logic              got8;
  logic              rw;
  logic              step_en;
  logic [IDXW-1:0]   ptr;
  logic              spi_q;
  logic              we;
  logic [7:0]        rdata;

  function automatic logic [IDXW-1:0] next_idx(input logic [IDXW-1:0] p);
    return (int'(p) == NREGS - 1) ? '0 : p + 1'b1;
  endfunction

  assign we = (state == ST_WR) && scl_fall && got8 && !spi_q && !stop_c && !start_c;

  i2c_regport_bank #(
    .NREGS(NREGS),
    .IDXW (IDXW)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (we),
    .widx_i (ptr),
    .wdata_i(shreg),
    .ridx_i (ptr),
    .rdata_o(rdata),
    .regs_o (regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_q <= 1'b0;
    end else if (strap_fall) begin
      spi_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      got8    <= 1'b0;
      rw      <= 1'b0;
      step_en <= 1'b0;
      ptr     <= '0;
    end else if (spi_q || stop_c) begin
      state  <= ST_IDLE;
      got8   <= 1'b0;
      bitcnt <= '0;
    end else if (start_c) begin
      state  <= ST_ADDR;
      got8   <= 1'b0;
      bitcnt <= '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8   <= 1'b0;
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == {ADDR_HI, strap_s}) begin
                rw    <= shreg[0];
                state <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ptr     <= shreg[IDXW-1:0];
              step_en <= shreg[7];
              state   <= ST_PTR_ACK;
            end else begin
              if (step_en) ptr <= next_idx(ptr);
              state <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw) begin
              shreg <= rdata;
              if (step_en) ptr <= next_idx(ptr);
              state <= ST_RD;
            end else begin
              state <= ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WR_ACK: begin
          if (scl_fall) state <= ST_WR;
        end
        ST_RD: begin
          if (scl_fall) begin
            shreg  <= {shreg[6:0], 1'b1};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              bitcnt <= '0;
              state  <= ST_RD_ACK;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_s) begin
            state <= ST_IDLE;
          end else if (scl_fall) begin
            shreg <= rdata;
            if (step_en) ptr <= next_idx(ptr);
            state <= ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_ADDR_ACK, ST_PTR_ACK, ST_WR_ACK: sda_oe_o = 1'b1;
      ST_RD:                              sda_oe_o = ~shreg[7];
      default:                            sda_oe_o = 1'b0;
    endcase
  end

  assign spi_mode_o = spi_q;

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int NREGS = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               spi_mode_o,
  input logic [NREGS*8-1:0] regs_o
);

  logic [NREGS*8-1:0] regs_q;
  logic [NREGS-1:0]   chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs_q <= '0;
    else        regs_q <= regs_o;
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_chg
    assign chg[i] = (regs_o[i*8 +: 8] != regs_q[i*8 +: 8]);
  end

  // R4 / R5: one received byte touches at most one register lane per cycle
  p_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(chg) <= 1);

  p_spi_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_o |=> spi_mode_o);

  p_spi_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_o |=> !sda_oe_o);

  p_regs_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spi_mode_o |=> $stable(regs_o));

  p_pull_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_i);

endmodule

bind i2c_regport i2c_regport_chk #(.NREGS(NREGS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe_o  (sda_oe_o),
  .spi_mode_o(spi_mode_o),
  .regs_o    (regs_o)
);

// File: tb/i2c_regport_tb.sv
module i2c_regport_tb;

  localparam int NREGS = 32;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic spi_mode;
  logic [NREGS*8-1:0] regs;
  logic sda_bus;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regport #(.NREGS(NREGS)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .strap_i   (strap),
    .spi_mode_o(spi_mode),
    .regs_o    (regs)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit settled = 1'b0;

  // reference model
  logic [NREGS*8-1:0] mvec = '0;
  int bptr = 0;
  bit bincr = 1'b0;
  bit mspi = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare register image and SPI flag on every settled clock
  always @(negedge clk) begin
    if (rst_n && settled && !done) begin
      tests++;
      if (regs !== mvec || spi_mode !== mspi) begin
        fails++;
        $display("FAIL R4 per-clock regs/flag: actual %0h/%0b expected %0h/%0b",
                 regs, spi_mode, mvec, mspi);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (scl == 1'b0) begin
      sda_m = 1'b1; wq(Q);
      scl = 1'b1;   wq(Q);
    end
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  // kind: 0 address, 1 pointer, 2 data, 3 ignored
  task automatic write_byte(input logic [7:0] b, input bit exp_ack,
                            input int kind, input string req);
    logic got;
    settled = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1;   wq(Q);
      scl = 1'b0;   wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q/2);
    got = ~sda_bus;
    chk(got == exp_ack, req, "ack", got, exp_ack);
    wq(Q/2);
    scl = 1'b0;   wq(Q);
    if (kind == 1) begin
      bptr  = b[4:0];
      bincr = b[7];
    end else if (kind == 2) begin
      mvec[bptr*8 +: 8] = b;
      if (bincr) bptr = (bptr + 1) % NREGS;
    end
    settled = 1'b1;
  endtask

  task automatic read_byte(input bit nack, input string req);
    logic [7:0] got;
    logic [7:0] exp;
    exp = mvec[bptr*8 +: 8];
    if (bincr) bptr = (bptr + 1) % NREGS;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(Q);
      scl = 1'b1;   wq(Q/2);
      got[i] = sda_bus;
      wq(Q/2);
      scl = 1'b0;   wq(Q);
    end
    chk(got == exp, req, "read byte", got, exp);
    sda_m = nack; wq(Q);
    scl = 1'b1;   wq(Q);
    scl = 1'b0;   wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    wq(5);
    rst_n = 1'b1;
    wq(6);
    // R9: reset state
    chk(regs == '0, "R9", "regs after reset", regs, 0);
    chk(sda_oe == 1'b0, "R9", "sda released", sda_oe, 0);
    chk(spi_mode == 1'b0, "R9", "spi flag", spi_mode, 0);
    settled = 1'b1;

    // R1 R3 R4: stepping write starting at 3
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h83, 1, 1, "R3");
    write_byte(8'hA1, 1, 2, "R4");
    write_byte(8'hB2, 1, 2, "R4");
    write_byte(8'hC3, 1, 2, "R4");
    bus_stop();

    // R5: fixed pointer writes land in one register
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h0A, 1, 1, "R5");
    write_byte(8'h11, 1, 2, "R5");
    write_byte(8'h22, 1, 2, "R5");
    write_byte(8'h33, 1, 2, "R5");
    bus_stop();
    chk(regs[10*8 +: 8] == 8'h33, "R5", "reg10", regs[10*8 +: 8], 8'h33);
    chk(regs[11*8 +: 8] == 8'h00, "R5", "reg11 untouched", regs[11*8 +: 8], 0);

    // R4: wrap from 31 to 0
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h9F, 1, 1, "R4");
    write_byte(8'h5A, 1, 2, "R4");
    write_byte(8'h6B, 1, 2, "R4");
    bus_stop();
    chk(regs[0 +: 8] == 8'h6B, "R4", "wrap to reg0", regs[0 +: 8], 8'h6B);

    // R3: bits 6..5 of pointer byte ignored
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'hE2, 1, 1, "R3");
    write_byte(8'h77, 1, 2, "R3");
    bus_stop();
    chk(regs[2*8 +: 8] == 8'h77, "R3", "reg2", regs[2*8 +: 8], 8'h77);

    // R6 R7 R8: pointer, repeated start, stepping read, NACK ends
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h83, 1, 1, "R3");
    bus_start();
    write_byte(8'h31, 1, 0, "R8");
    read_byte(1'b0, "R6");
    read_byte(1'b0, "R6");
    read_byte(1'b1, "R7");
    wq(Q);
    chk(sda_oe == 1'b0, "R7", "released after NACK", sda_oe, 0);
    bus_stop();

    // R6: fixed pointer read repeats the same register
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h0A, 1, 1, "R3");
    bus_start();
    write_byte(8'h31, 1, 0, "R8");
    read_byte(1'b0, "R6");
    read_byte(1'b1, "R6");
    bus_stop();

    // R2: wrong address, following bytes ignored
    bus_start();
    write_byte(8'h32, 0, 0, "R2");
    write_byte(8'h05, 0, 3, "R2");
    write_byte(8'hFF, 0, 3, "R2");
    bus_stop();
    chk(regs == mvec, "R2", "regs unchanged", 0, 0);

    // R8: STOP right after address, then fresh pointer byte
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    bus_stop();
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h01, 1, 1, "R8");
    write_byte(8'h99, 1, 2, "R8");
    bus_stop();
    chk(regs[1*8 +: 8] == 8'h99, "R8", "reg1", regs[1*8 +: 8], 8'h99);

    // R8: repeated start inside a write makes the next byte a pointer again
    bus_start();
    write_byte(8'h30, 1, 0, "R1");
    write_byte(8'h8C, 1, 1, "R3");
    write_byte(8'h44, 1, 2, "R4");
    bus_start();
    write_byte(8'h30, 1, 0, "R8");
    write_byte(8'h0D, 1, 1, "R8");
    write_byte(8'h55, 1, 2, "R8");
    bus_stop();
    chk(regs[13*8 +: 8] == 8'h55, "R8", "reg13", regs[13*8 +: 8], 8'h55);
    chk(regs[12*8 +: 8] == 8'h44, "R8", "reg12", regs[12*8 +: 8], 8'h44);

    // R1: strap high moves the address; old address now refused
    strap = 1'b1;
    wq(Q);
    bus_start();
    write_byte(8'h32, 1, 0, "R1");
    write_byte(8'h14, 1, 1, "R3");
    write_byte(8'hEE, 1, 2, "R5");
    bus_stop();
    bus_start();
    write_byte(8'h30, 0, 0, "R2");
    bus_stop();
    chk(spi_mode == 1'b0, "R10", "rising strap leaves flag", spi_mode, 0);

    // R10: falling strap sets sticky SPI flag
    settled = 1'b0;
    strap = 1'b0;
    wq(6);
    mspi = 1'b1;
    chk(spi_mode == 1'b1, "R10", "flag after fall", spi_mode, 1);
    settled = 1'b1;
    bus_start();
    write_byte(8'h30, 0, 0, "R10");
    write_byte(8'h85, 0, 3, "R10");
    write_byte(8'h3C, 0, 3, "R10");
    bus_stop();
    strap = 1'b1;
    wq(Q);
    chk(spi_mode == 1'b1, "R10", "flag sticky", spi_mode, 1);
    chk(regs == mvec, "R10", "regs frozen", 0, 0);
    chk(sda_oe == 1'b0, "R10", "no drive", sda_oe, 0);

    finish_run();
  end

endmodule